// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This peripheral guards a system against hung software. Software sets it up through a small register window. The configuration holds an enable bit, a power field, a divider select and a 16-bit reload count. That configuration can only be changed by a two-write unlock. The first write to the control offset must be exactly the opening key word. The very next control write must carry the closing key byte, and it supplies the new configuration in the same word.

Once enabled, a prescaler derives a count tick from the clock, and the down-counter loses one count per tick. When the count runs out, the block pulses a reset request for one clock and records a sticky flag. That flag survives until power-on reset. Software keeps the system alive by replaying the unlock with a fresh reload value. A closing key sent with every configuration bit clear switches the watchdog off.

A status offset returns the live configuration, the sticky flag and the current count.

Top module: `pwd_watchdog`

## Requirements
- R1: While and after `rst` is high, the watchdog is disabled, the count and sticky flag are zero, `wdt_rst_req` is low and `bus_rdata` is zero.
- R2: A control write (offset 0x0) of exactly 0x00BE0000 arms the unlock. If the next control write has 0xDC in bits 23:16, it takes enable from bit 31, power from bits 27:26, divider select from bits 25:24 and the reload value from bits 15:0. Bits 30:28 are ignored. The reload value is loaded into the counter in the same clock edge.
- R3: When the unlock is armed, any control write that lacks 0xDC in bits 23:16 abandons the sequence and changes nothing. This includes a repeat of the opening key. Any control write disarms the unlock.
- R4: A control write that does not immediately follow the opening key leaves the configuration and the count unchanged.
- R5: A valid key pair whose second word has every configuration bit clear disables the watchdog. After that, the count holds and no reset request is raised.
- R6: When enabled, the counter decrements once every 2^L clock cycles. L is the log2 divisor chosen by the divider select; select 3 defaults to L=18. A reload of N therefore expires N·2^L cycles after the loading edge, or 2^L cycles after it when N is 0.
- R7: On expiry, `wdt_rst_req` is high for exactly one cycle, the enable bit clears and the sticky flag sets.
- R8: Replaying a valid key pair while counting reloads the counter and restarts the prescaler. No request is raised before the new period ends.
- R9: A read of the status offset (0x8) returns the following fields in `bus_rdata` on the next cycle:
  - bit 31: enable
  - bit 30: sticky flag
  - bits 27:26: power field
  - bits 25:24: divider select
  - bits 15:0: live count
  - all other bits: zero
- R10: Writes to any offset other than 0x0 are ignored, and they neither arm nor disarm the unlock.
- R11: An opening word that differs from 0x00BE0000 in any bit does not arm the unlock.
- R12: The sticky flag is cleared only by `rst`. Writing a key pair does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
A valid second key takes effect on the clock edge that samples it. Read data appears one cycle after the read strobe, so every status check issues a read after the write and samples at the following falling edge. Expiry is checked by counting falling edges from the loading edge until `wdt_rst_req` is seen, and the count must equal reload times 2^L. The falling edge after that must show the request low again. The live-count check reads at a fixed offset inside a tick period, well away from any decrement edge, so the expected value is exact.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0] KEY_OPEN  = 8'hBE;
  localparam logic [7:0] KEY_CLOSE = 8'hDC;

  typedef struct packed {
    logic       en;
    logic [1:0] pwr;
    logic [1:0] div;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RELOAD_W = 16,
  parameter int CTRL_OFF = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                expire_i,
  output wdt_cfg_t            cfg_o,
  output logic                load_o,
  output logic [RELOAD_W-1:0] reload_o
);
  localparam logic [WORD_W-1:0] OPEN_WORD = {8'h00, KEY_OPEN, 16'h0000};

  logic     armed_q;
  wdt_cfg_t cfg_q;
  logic     ctrl_wr, open_ok, close_ok;

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_OFF));
  assign open_ok  = (wdata == OPEN_WORD);
  assign close_ok = (wdata[23:16] == KEY_CLOSE);
  assign load_o   = ctrl_wr && armed_q && close_ok;
  assign reload_o = wdata[RELOAD_W-1:0];
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (ctrl_wr)
      armed_q <= !armed_q && open_ok;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (load_o)
      cfg_q <= '{en: wdata[31], pwr: wdata[27:26], div: wdata[25:24]};
    else if (expire_i)
      cfg_q.en <= 1'b0;
  end

  // R3
  armed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && ctrl_wr) |=> !armed_q);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_o && !expire_i) |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int LOG2_D0 = 12,
  parameter int LOG2_D1 = 14,
  parameter int LOG2_D2 = 16,
  parameter int LOG2_D3 = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       clear_i,
  output logic       tick_o
);
  function automatic int pick(int s);
    case (s)
      0:       return LOG2_D0;
      1:       return LOG2_D1;
      2:       return LOG2_D2;
      default: return LOG2_D3;
    endcase
  endfunction

  function automatic int widest();
    int m;
    m = 1;
    for (int i = 0; i < 4; i++)
      if (pick(i) > m) m = pick(i);
    return m;
  endfunction

  localparam int PRE_W = widest();

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_tab [4];
  logic [PRE_W-1:0] mask;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    localparam int L = pick(g);
    assign mask_tab[g] = PRE_W'((64'd1 << L) - 64'd1);
  end

  assign mask   = mask_tab[sel_i];
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      pre_q <= '0;
    else if (en_i)
      pre_q <= pre_q + 1'b1;
  end

  // R8
  pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                en_i,
  input  logic                tick_i,
  output logic [RELOAD_W-1:0] cnt_o,
  output logic                expire_o,
  output logic                rst_req_o,
  output logic                flag_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                req_q, flag_q;

  assign expire_o  = en_i && tick_i && !load_i && (cnt_q <= RELOAD_W'(1));
  assign cnt_o     = cnt_q;
  assign rst_req_o = req_q;
  assign flag_o    = flag_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= reload_i;
    else if (en_i && tick_i && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= expire_o;
      flag_q <= flag_q || expire_o;
    end
  end

  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> flag_q);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RELOAD_W = 16,
  parameter int CTRL_OFF = 0,
  parameter int STAT_OFF = 8,
  parameter int LOG2_D0  = 12,
  parameter int LOG2_D1  = 14,
  parameter int LOG2_D2  = 16,
  parameter int LOG2_D3  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  wdt_cfg_t            cfg;
  logic                load, expire, tick, flag;
  logic [RELOAD_W-1:0] reload, cnt;
  logic [31:0]         stat_word, rdata_q;

  wdt_unlock #(.ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W), .CTRL_OFF(CTRL_OFF)) u_unlock (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire_i(expire), .cfg_o(cfg), .load_o(load), .reload_o(reload)
  );

  wdt_prescaler #(.LOG2_D0(LOG2_D0), .LOG2_D1(LOG2_D1),
                  .LOG2_D2(LOG2_D2), .LOG2_D3(LOG2_D3)) u_pre (
    .clk(clk), .rst(rst), .en_i(cfg.en), .sel_i(cfg.div),
    .clear_i(load), .tick_o(tick)
  );

  wdt_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .reload_i(reload), .en_i(cfg.en),
    .tick_i(tick), .cnt_o(cnt), .expire_o(expire), .rst_req_o(wdt_rst_req),
    .flag_o(flag)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[31]             = cfg.en;
    stat_word[30]             = flag;
    stat_word[27:26]          = cfg.pwr;
    stat_word[25:24]          = cfg.div;
    stat_word[RELOAD_W-1:0]   = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= (bus_addr == ADDR_W'(STAT_OFF)) ? stat_word : '0;
  end

  assign bus_rdata = rdata_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!wdt_rst_req && bus_rdata == '0));
endmodule

// File: tb/sim_pwd_watchdog.sv
`timescale 1ns/1ps
module sim_pwd_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pwd_watchdog #(.LOG2_D0(0), .LOG2_D1(2), .LOG2_D2(4), .LOG2_D3(6)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  // {req, addr, data, expected status}
  localparam int NV = 18;
  localparam logic [71:0] VEC [NV] = '{
    {4'd4,  4'h0, 32'h12345678, 32'h00000000},  // R4 unarmed write
    {4'd2,  4'h0, 32'h00BE0000, 32'h00000000},  // R2 open
    {4'd2,  4'h0, 32'h0BDC1234, 32'h0B001234},  // R2 close + config
    {4'd3,  4'h0, 32'h00BE0000, 32'h0B001234},  // R3 open
    {4'd3,  4'h0, 32'h8ADD0055, 32'h0B001234},  // R3 bad close key
    {4'd4,  4'h0, 32'h00DC0000, 32'h0B001234},  // R4 lone close
    {4'd11, 4'h0, 32'h00BE0001, 32'h0B001234},  // R11 inexact open
    {4'd11, 4'h0, 32'h00DC0007, 32'h0B001234},  // R11 close not armed
    {4'd3,  4'h0, 32'h00BE0000, 32'h0B001234},  // R3 open
    {4'd3,  4'h0, 32'h00BE0000, 32'h0B001234},  // R3 repeat open aborts
    {4'd3,  4'h0, 32'h00DC0003, 32'h0B001234},  // R3 close after abort
    {4'd10, 4'h8, 32'h00BE0000, 32'h0B001234},  // R10 open at status offset
    {4'd10, 4'h0, 32'h00DC0009, 32'h0B001234},  // R10 close not armed
    {4'd10, 4'h0, 32'h00BE0000, 32'h0B001234},  // R10 open
    {4'd10, 4'h8, 32'h8FDC0099, 32'h0B001234},  // R10 stray write keeps arm
    {4'd10, 4'h0, 32'h0ADC0042, 32'h0A000042},  // R10 close accepted
    {4'd5,  4'h0, 32'h00BE0000, 32'h0A000042},  // R5 open
    {4'd5,  4'h0, 32'h00DC0000, 32'h00000000}   // R5 disable
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_req(int limit, output int n);
    n = 0;
    while (!wdt_rst_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    int n;
    bit early;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 req", {31'b0, wdt_rst_req}, 32'h0);
    rd(4'h8, s); check("R1 status", s, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(4'h8, s);
      check($sformatf("R%0d vec %0d", VEC[i][71:68], i), s, VEC[i][31:0]);
    end

    // R6 R7 div select 3 (2^6), reload 5 -> 320 cycles
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h83DC0005);
    wait_req(2000, n);
    check("R6 expiry cycles div3", n, 320);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, wdt_rst_req}, 32'h0);
    rd(4'h8, s); check("R7 R9 status after expiry", s, 32'h43000000);

    // R6 div select 1 (2^2), reload 3 -> 12 cycles
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h81DC0003);
    wait_req(2000, n);
    check("R6 expiry cycles div1", n, 12);

    // R8 keepalive, div select 0, reload 20
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h80DC0014);
    early = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (wdt_rst_req) early = 1;
    end
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h80DC0014);
    check("R8 no early request", {31'b0, early}, 32'h0);
    wait_req(2000, n);
    check("R8 reloaded period", n, 20);

    // R9 live count, div select 3, reload 100
    @(negedge clk);
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h83DC0064);
    repeat (199) @(negedge clk);
    rd(4'h8, s); check("R9 live count", s, 32'hC3000061);

    // R5 R12 disable keeps flag, no request
    wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h00DC0000);
    rd(4'h8, s); check("R5 R12 disabled status", s, 32'h40000000);
    wait_req(8000, n);
    check("R5 no request after disable", n, 8000);

    // R1 R12 reset clears flag
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 req after reset", {31'b0, wdt_rst_req}, 32'h0);
    rd(4'h8, s); check("R12 flag cleared by reset", s, 32'h0);

    finish_run();
  end
endmodule